// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the register-side slave of a shared-memory notification device that lets processors sharing a memory window signal one another. It exposes four 32-bit registers on a simple register bus: an interrupt enable mask, an interrupt status word, a read-only identity register and a write-only doorbell. The AND of status and mask drives a level interrupt line, unless message-based interrupt delivery is selected or the interrupt pin is configured off.

A doorbell write names a destination peer and a vector. The write is checked against the number of known peers and against a per-peer vector-count table. If both checks pass, a single-cycle notify pulse carries the destination and the vector to the transport logic. A failed check drops the write without any trace. An inbound event from the transport sets the local status to 1. Reading status returns its value and clears it in the same access.

Top module: `dbell_regs`

## Requirements
- R1: Only address bits 7:2 are decoded (a 256-byte window of 32-bit words). Address bits 1:0 have no effect on any access.
- R2: Word offsets are fixed: 0x00 is the mask, 0x04 is the status, 0x08 is the own ID and 0x0C is the doorbell.
- R3: With `msi_mode`=0 and `irq_pin_en`=1, `irq` is high exactly when status AND mask is nonzero. It updates on the same clock edge as the register change that causes it.
- R4: A read of status returns the status value held before the access. The same edge clears status to zero.
- R5: A write to the mask or to status replaces the whole 32-bit register. Reading the mask returns it unchanged.
- R6: A doorbell write takes the destination from data bits 31:16 and the vector from bits 7:0. When accepted, it raises `ntf_vld` for exactly the one cycle after the write, with `ntf_dest` and `ntf_vec` set to those fields.
- R7: A doorbell is dropped with no pulse when its destination is not below `cfg_npeers` or not below NUM_PEERS.
- R8: A doorbell is dropped with no pulse when its vector is not below the vector count that was loaded for that destination through `cfg_we`/`cfg_peer`/`cfg_vcnt`.
- R9: Reads of the doorbell offset or of any unmapped offset return zero. Writes to unmapped offsets change no register.
- R10: Reset clears the mask, status, `irq`, `ntf_vld` and the read data.
- R11: With `msi_mode`=0, an `evt_in` pulse writes the value 1 into status. With `msi_mode`=1 it leaves status unchanged.
- R12: `irq` is held low whenever `msi_mode`=1 or `irq_pin_en`=0.
- R13: When a status read and an `evt_in` pulse (with `msi_mode`=0) fall in the same cycle, the read returns the old value and status ends at 1.
- R14: A read of the own-ID register returns `own_id`, zero-extended. A write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| own_id | input | ID_W | Identity of this node |
| msi_mode | input | 1 | Message interrupt mode; forces `irq` low and blocks `evt_in` |
| irq_pin_en | input | 1 | Interrupt pin configured; when 0, `irq` stays low |
| evt_in | input | 1 | Inbound event pulse |
| cfg_npeers | input | PIDX_W+1 | Number of known peers |
| cfg_we | input | 1 | Vector-count table write |
| cfg_peer | input | PIDX_W | Table entry index |
| cfg_vcnt | input | VEC_W+1 | Vector count for that peer |
| irq | output | 1 | Level interrupt |
| ntf_vld | output | 1 | Notify pulse |
| ntf_dest | output | ID_W | Notify destination |
| ntf_vec | output | VEC_W | Notify vector |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that the table is loaded before doorbells are rung, and that `msi_mode` and `irq_pin_en` are steady for the cycle in which they are sampled. The stimulus drives each access as a single-cycle strobe: it is either a read or a write, never both. Every table entry is written before the random phase starts, and the two mode inputs change only between accesses. Random addresses cover the whole 256-byte window with random low bits. Random doorbell fields reach past the peer count, past NUM_PEERS and past each vector count.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int DATA_W = 32;

  // word offsets (bits 7:2 of the byte address)
  localparam logic [5:0] OFS_MASK = 6'd0;
  localparam logic [5:0] OFS_STAT = 6'd1;
  localparam logic [5:0] OFS_ID   = 6'd2;
  localparam logic [5:0] OFS_RING = 6'd3;

  typedef enum logic [2:0] {
    SEL_MASK,
    SEL_STAT,
    SEL_ID,
    SEL_RING,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [5:0] word);
    case (word)
      OFS_MASK: decode_word = SEL_MASK;
      OFS_STAT: decode_word = SEL_STAT;
      OFS_ID:   decode_word = SEL_ID;
      OFS_RING: decode_word = SEL_RING;
      default:  decode_word = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dbell_vec_table.sv
module dbell_vec_table #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 9,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  // small table: distributed RAM, asynchronous read
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dbell_irq_ctrl.sv
module dbell_irq_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we,
  input  logic              stat_we,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt,
  input  logic              msi_mode,
  input  logic              pin_en,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq
);
  logic [DATA_W-1:0] mask_d, stat_d;
  logic              evt_take, line_en;

  assign evt_take = evt && !msi_mode;
  assign line_en  = pin_en && !msi_mode;

  always_comb begin
    mask_d = mask_q;
    stat_d = stat_q;
    if (mask_we) mask_d = wdata;
    // event has priority over the read-clear so no event is lost
    if (evt_take)     stat_d = DATA_W'(1);
    else if (stat_rd) stat_d = '0;
    else if (stat_we) stat_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq    <= line_en && (|(stat_d & mask_d));
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '0 && stat_q == '0 && !irq)); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == ((|(stat_q & mask_q)) && $past(line_en))); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(msi_mode || !pin_en) |-> !irq); // R12
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !evt_take) |=> stat_q == '0); // R4
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    evt_take |=> stat_q == DATA_W'(1)); // R13
endmodule

// File: rtl/dbell_ring.sv
module dbell_ring #(
  parameter int DATA_W    = 32,
  parameter int NUM_PEERS = 8,
  parameter int ID_W      = 16,
  parameter int VEC_W     = 8,
  localparam int PIDX_W   = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1,
  localparam int VCNT_W   = VEC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PIDX_W:0]   npeers,
  input  logic              cfg_we,
  input  logic [PIDX_W-1:0] cfg_peer,
  input  logic [VCNT_W-1:0] cfg_vcnt,
  output logic              ntf_vld,
  output logic [ID_W-1:0]   ntf_dest,
  output logic [VEC_W-1:0]  ntf_vec
);
  localparam int DEST_LSB = DATA_W - ID_W;

  logic [ID_W-1:0]   dest;
  logic [VEC_W-1:0]  vec;
  logic [ID_W-1:0]   npeers_ext;
  logic [VCNT_W-1:0] vcnt;
  logic              dest_ok, vec_ok;

  assign dest       = wdata[DATA_W-1:DEST_LSB];
  assign vec        = wdata[VEC_W-1:0];
  assign npeers_ext = ID_W'(npeers);

  dbell_vec_table #(.DEPTH(NUM_PEERS), .WIDTH(VCNT_W)) u_tbl (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_peer),
    .wdata (cfg_vcnt),
    .raddr (dest[PIDX_W-1:0]),
    .rdata (vcnt)
  );

  assign dest_ok = (dest < npeers_ext) && (dest < ID_W'(NUM_PEERS));
  assign vec_ok  = ({1'b0, vec} < vcnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ntf_vld  <= 1'b0;
      ntf_dest <= '0;
      ntf_vec  <= '0;
    end else begin
      ntf_vld <= ring_we && dest_ok && vec_ok;
      if (ring_we) begin
        ntf_dest <= dest;
        ntf_vec  <= vec;
      end
    end
  end

  AST_NTF_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    ntf_vld |-> $past(ring_we)); // R6
  AST_NTF_PEER_RANGE: assert property (@(posedge clk) disable iff (rst)
    ntf_vld |-> (ntf_dest < $past(npeers_ext) && ntf_dest < ID_W'(NUM_PEERS))); // R7
  AST_NTF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ring_we |=> !ntf_vld); // R6
endmodule

// File: rtl/dbell_regs.sv
module dbell_regs
  import dbell_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PEERS = 8,
  parameter int ID_W      = 16,
  parameter int VEC_W     = 8,
  localparam int PIDX_W   = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1,
  localparam int VCNT_W   = VEC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [ID_W-1:0]   own_id,
  input  logic              msi_mode,
  input  logic              irq_pin_en,
  input  logic              evt_in,
  input  logic [PIDX_W:0]   cfg_npeers,
  input  logic              cfg_we,
  input  logic [PIDX_W-1:0] cfg_peer,
  input  logic [VCNT_W-1:0] cfg_vcnt,
  output logic              irq,
  output logic              ntf_vld,
  output logic [ID_W-1:0]   ntf_dest,
  output logic [VEC_W-1:0]  ntf_vec
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] mask_q, stat_q, rd_mux;

  // low two address bits dropped before decode
  assign sel = decode_word(6'(bus_addr[ADDR_W-1:2]));

  dbell_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .mask_we  (bus_wr && sel == SEL_MASK),
    .stat_we  (bus_wr && sel == SEL_STAT),
    .stat_rd  (bus_rd && sel == SEL_STAT),
    .wdata    (bus_wdata),
    .evt      (evt_in),
    .msi_mode (msi_mode),
    .pin_en   (irq_pin_en),
    .mask_q   (mask_q),
    .stat_q   (stat_q),
    .irq      (irq)
  );

  dbell_ring #(.DATA_W(DATA_W), .NUM_PEERS(NUM_PEERS), .ID_W(ID_W), .VEC_W(VEC_W)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .ring_we  (bus_wr && sel == SEL_RING),
    .wdata    (bus_wdata),
    .npeers   (cfg_npeers),
    .cfg_we   (cfg_we),
    .cfg_peer (cfg_peer),
    .cfg_vcnt (cfg_vcnt),
    .ntf_vld  (ntf_vld),
    .ntf_dest (ntf_dest),
    .ntf_vec  (ntf_vec)
  );

  always_comb begin
    case (sel)
      SEL_MASK: rd_mux = mask_q;
      SEL_STAT: rd_mux = stat_q;
      SEL_ID:   rd_mux = DATA_W'(own_id);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (sel == SEL_RING || sel == SEL_NONE)) |=> bus_rdata == '0); // R9
  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_ID) |=> bus_rdata == DATA_W'($past(own_id))); // R14
endmodule

// File: tb/tb_dbell_regs.sv
module tb_dbell_regs;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] own_id = 16'h5A3C;
  logic        msi_mode = 1'b0, irq_pin_en = 1'b1, evt_in = 1'b0;
  logic [3:0]  cfg_npeers = 4'd6;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_peer = '0;
  logic [8:0]  cfg_vcnt = '0;
  logic        irq, ntf_vld;
  logic [15:0] ntf_dest;
  logic [7:0]  ntf_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_mask = '0, m_stat = '0;
  logic [8:0]  tbl [NP];

  always #2.5 clk = ~clk;

  dbell_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .own_id(own_id), .msi_mode(msi_mode),
    .irq_pin_en(irq_pin_en), .evt_in(evt_in), .cfg_npeers(cfg_npeers), .cfg_we(cfg_we),
    .cfg_peer(cfg_peer), .cfg_vcnt(cfg_vcnt), .irq(irq), .ntf_vld(ntf_vld),
    .ntf_dest(ntf_dest), .ntf_vec(ntf_vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a & 8'hFC)
      8'h00:   return m_mask;
      8'h04:   return m_stat;
      8'h08:   return {16'h0, own_id};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|(m_stat & m_mask)) && !msi_mode && irq_pin_en;
  endfunction

  // one bus access (or idle), checks the outputs one edge later
  task automatic op(input logic we, input logic re, input logic [7:0] a,
                    input logic [31:0] d, input logic ev, input string tag);
    logic [31:0] erd;
    logic [7:0]  w;
    logic        ering, dok;
    string       rtag;
    w = a & 8'hFC;
    erd = exp_read(a);
    dok = (d[31:16] < 16'(cfg_npeers)) && (d[31:16] < 16'(NP));
    ering = we && w == 8'h0C && dok && ({1'b0, d[7:0]} < tbl[d[18:16]]);
    rtag = !dok ? "R7" : (ering ? "R6" : "R8");
    @(negedge clk);
    bus_wr = we; bus_rd = re; bus_addr = a; bus_wdata = d; evt_in = ev;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; evt_in = 0;
    if (ev && !msi_mode) m_stat = 32'd1;
    else if (re && w == 8'h04) m_stat = '0;
    else if (we && w == 8'h04) m_stat = d;
    if (we && w == 8'h00) m_mask = d;
    if (re) chk({tag, " rdata"}, bus_rdata, erd);
    chk({tag, " R3 irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    if (we && w == 8'h0C) begin
      chk({rtag, " ntf_vld"}, {31'b0, ntf_vld}, {31'b0, ering});
      if (ering) chk("R6 ntf fields", {ntf_dest, ntf_vec, 8'h0}, {d[31:16], d[7:0], 8'h0});
    end else chk({tag, " R6 no pulse"}, {31'b0, ntf_vld}, 32'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq", {31'b0, irq}, 0);
    chk("R10 ntf", {31'b0, ntf_vld}, 0);
    chk("R10 rdata", bus_rdata, 0);
    for (int i = 0; i < NP; i++) begin
      tbl[i] = 9'((i * 3) % 5);
      @(negedge clk);
      cfg_we = 1; cfg_peer = 3'(i); cfg_vcnt = tbl[i];
    end
    @(negedge clk); cfg_we = 0;
    rst = 0;
    op(0, 1, 8'h00, 0, 0, "R10 mask");
    op(0, 1, 8'h04, 0, 0, "R10 stat");
    // R2 / R5 / R1 directed
    op(1, 0, 8'h03, 32'hDEAD_BEEF, 0, "R1 mask wr lowbits");
    op(0, 1, 8'h01, 0, 0, "R1 R5 mask rd");
    op(1, 0, 8'h06, 32'h0000_0F00, 0, "R5 stat wr");
    op(0, 1, 8'h04, 0, 0, "R4 stat rd");
    op(0, 1, 8'h04, 0, 0, "R4 stat cleared");
    op(1, 0, 8'h08, 32'hFFFF_FFFF, 0, "R14 id wr");
    op(0, 1, 8'h0A, 0, 0, "R14 R2 id rd");
    op(1, 0, 8'h40, 32'h1234_5678, 0, "R9 unmapped wr");
    op(0, 1, 8'h00, 0, 0, "R9 mask intact");
    op(0, 1, 8'h0C, 0, 0, "R9 ring rd");
    op(0, 1, 8'hFC, 0, 0, "R9 top rd");
    // R11 / R13
    op(1, 0, 8'h00, 32'h1, 0, "R3 mask1");
    op(0, 0, 8'h00, 0, 1, "R11 event");
    op(1, 0, 8'h04, 32'hF0, 0, "R5 stat wr");
    op(0, 1, 8'h04, 0, 1, "R13 rd+evt");
    op(0, 1, 8'h04, 0, 0, "R13 stat is 1");
    // R12
    op(1, 0, 8'h04, 32'h3, 0, "R3 set");
    irq_pin_en = 0;
    op(0, 0, 8'h00, 0, 0, "R12 pin off");
    irq_pin_en = 1; msi_mode = 1;
    op(0, 0, 8'h00, 0, 1, "R12 R11 msi evt ignored");
    op(0, 1, 8'h04, 0, 0, "R11 stat unchanged");
    msi_mode = 0;
    // doorbells R6 R7 R8
    op(1, 0, 8'h0C, {16'd1, 8'h0, 8'd2}, 0, "R6 ok");
    op(1, 0, 8'h0D, {16'd3, 8'hAA, 8'd3}, 0, "R6 top vec");
    op(1, 0, 8'h0C, {16'd3, 8'h0, 8'd4}, 0, "R8 vec=cnt");
    op(1, 0, 8'h0C, {16'd0, 8'h0, 8'd0}, 0, "R8 zero cnt");
    op(1, 0, 8'h0C, {16'd6, 8'h0, 8'd0}, 0, "R7 dest=npeers");
    op(1, 0, 8'h0C, {16'd9, 8'h0, 8'd0}, 0, "R7 dest>NP");
    cfg_npeers = 4'd9;
    op(1, 0, 8'h0C, {16'd8, 8'h0, 8'd0}, 0, "R7 dest=NP");
    cfg_npeers = 4'd6;
    // constrained random
    for (int k = 0; k < 600; k++) begin
      int kind;
      logic [7:0]  a;
      logic [31:0] d;
      logic        we;
      kind = $urandom_range(0, 9);
      case (kind)
        0, 1:    a = 8'h00;
        2, 3:    a = 8'h04;
        4:       a = 8'h08;
        5, 6, 7: a = 8'h0C;
        default: a = 8'($urandom_range(0, 63) << 2);
      endcase
      a = a | 8'($urandom_range(0, 3));
      d = $urandom;
      if (kind == 2 || kind == 3) d = d & 32'h0000_00FF;
      if (kind >= 5 && kind <= 7) d = {16'($urandom_range(0, 10)), 8'($urandom), 8'($urandom_range(0, 5))};
      we = (kind >= 5 && kind <= 7) ? ($urandom_range(0, 7) != 0) : $urandom_range(0, 1) == 1;
      if (k % 50 == 49) begin
        msi_mode = ($urandom_range(0, 3) == 0);
        irq_pin_en = ($urandom_range(0, 3) != 0);
      end
      op(we, !we, a, d, $urandom_range(0, 7) == 0, "R3 R5 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule